// File: doc/BRIEF.md
# Serial Transmit Path with Holding Stage and Empty Flags

This block is the sending half of a classic asynchronous serial port. The host pushes bytes through a write strobe into a holding stage. A control bit picks the form of that stage: either a single holding register or a first-in first-out queue of `DEPTH` entries. A shift engine takes one byte at a time from the holding stage and sends it as a frame on the serial line. The frame is one low start bit, eight data bits with the least significant bit first, an optional even or odd parity bit and one high stop bit. Every bit lasts sixteen pulses of an oversampling enable that an external baud divider supplies.

The block drives three status signals for the host. One shows that the holding stage is empty. One shows that the whole transmitter is empty. The third is an interrupt request for the empty condition, gated by an enable bit. In queue mode the interrupt fires when the fill level drops below a programmable trigger level, and again when the queue drains. In single-register mode it fires when the held byte moves into the shift engine. A read of the interrupt status, or an accepted write, withdraws a pending request.

The shift engine is a state machine with five states: `ST_IDLE` (line high, waiting), `ST_START` (start bit), `ST_DATA` (eight data bits), `ST_PARITY` (parity bit) and `ST_STOP` (stop bit). Its transitions are: *load*, ST_IDLE→ST_START when the holding stage has a byte; *begin data*, ST_START→ST_DATA at the end of a bit; *data to parity*, ST_DATA→ST_PARITY after the last data bit when parity is on; *data to stop*, ST_DATA→ST_STOP after the last data bit when parity is off; *parity to stop*, ST_PARITY→ST_STOP; and *frame done*, ST_STOP→ST_IDLE.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, tx_out is 1, thr_empty is 1, tx_empty is 1 and tx_irq is 0.
- R2: Each frame on tx_out is a 0 start bit, then wr_data bits 0 through 7 in that order, then a parity bit when par_en was 1 at load, then a 1 stop bit. Every bit lasts exactly 16 baud_tick pulses. The parity bit is the XOR of the data bits, inverted when par_odd is 1.
- R3: With fifo_en at 1, the queue holds up to 16 bytes. A write that arrives while the queue is full is dropped, and bytes leave in the order they were written.
- R4: With fifo_en at 0, the holding stage holds one byte. thr_empty goes to 1 in the cycle the byte moves into the shift engine. A write that arrives while the register is occupied is dropped.
- R5: tx_empty is 1 only when the holding stage is empty and the shift engine is idle, so it rises only after the stop bit has fully elapsed.
- R6: With fifo_en at 1, thr_empty is 1 exactly when the queue holds no byte.
- R7: With fifo_en at 1, the empty interrupt is raised when a byte leaving the queue takes the fill level from at least the trigger level to below it. trig_sel codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14.
- R8: The empty interrupt is also raised when a byte leaves and the holding stage becomes empty, in either mode.
- R9: tx_irq is the pending request ANDed with irq_en. A request raised while irq_en is 0 stays pending and appears once irq_en goes to 1.
- R10: A pulse on isr_rd, or an accepted write, clears a pending request. A new raising condition in the same cycle takes priority.
- R11: Any change of fifo_en discards every byte in the holding stage. A byte already in the shift engine is still sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single holding register |
| trig_sel | input | 2 | Trigger level code for the empty interrupt |
| par_en | input | 1 | Adds a parity bit to the frame |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| irq_en | input | 1 | Enables the empty interrupt output |
| wr_en | input | 1 | Host write strobe into the holding stage |
| wr_data | input | 8 | Byte to send |
| isr_rd | input | 1 | Host read of the interrupt status; clears a pending request |
| tx_out | output | 1 | Serial line |
| thr_empty | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Holding stage and shift engine both empty |
| tx_irq | output | 1 | Empty interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-entry queue, 8 data bits and 16 ticks per bit. With these values a single stalled burst of 20 writes fills the queue and overruns it, and every trigger code can be reached, including level 14. Because the queue depth equals the trigger ceiling plus two, each trigger crossing occurs after a distinct, predictable number of completed frames. A random tick density, from every cycle down to sparse, checks that bit timing follows baud_tick and not the clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    // Fill level below which the empty interrupt fires in queue mode
    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          avail,
    output logic          wr_ok
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          mode_q;
    logic          flush;
    logic          do_pop;
    logic [CW-1:0] cap;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        flush   = (fifo_en != mode_q);
        cap     = fifo_en ? CW'(DEPTH) : CW'(1);
        wr_ok   = wr_en && !flush && (cnt_q < cap);
        avail   = (cnt_q != '0) && !flush;
        do_pop  = pop && avail;
        rd_data = mem[rp_q];
        count   = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_en;
            if (flush) begin
                wp_q  <= '0;
                rp_q  <= '0;
                cnt_q <= '0;
            end else begin
                if (wr_ok)  wp_q <= bump(wp_q);
                if (do_pop) rp_q <= bump(rp_q);
                cnt_q <= cnt_q + CW'(wr_ok) - CW'(do_pop);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp_q] <= wr_data;
    end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16,
    localparam int TW = $clog2(OVS),
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          avail,
    input  logic [DW-1:0] din,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          load,
    output logic          busy,
    output logic          line
);

    localparam logic [TW-1:0] LAST_TICK = TW'(OVS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DW - 1);

    tx_state_t     state_q, state_d;
    logic [TW-1:0] tk_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sr_q;
    logic          par_q, pen_q;
    logic          bit_end;

    assign bit_end = tick && (tk_q == LAST_TICK);
    assign load    = (state_q == ST_IDLE) && avail;
    assign busy    = (state_q != ST_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (avail)   state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && bit_q == LAST_BIT)
                           state_d = pen_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (bit_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_q  <= '0;
            bit_q <= '0;
            sr_q  <= '0;
            par_q <= 1'b0;
            pen_q <= 1'b0;
        end else if (load) begin
            tk_q  <= '0;
            bit_q <= '0;
            sr_q  <= din;
            par_q <= (^din) ^ par_odd;
            pen_q <= par_en;
        end else if (tick && busy) begin
            tk_q <= bit_end ? '0 : tk_q + TW'(1);
            if (bit_end && state_q == ST_DATA) begin
                sr_q  <= sr_q >> 1;
                bit_q <= bit_q + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START:  line = 1'b0;
            ST_DATA:   line = sr_q[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
    import uart_tx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    input  logic          pop,
    input  logic          wr_ok,
    input  logic          isr_rd,
    input  logic          irq_en,
    output logic          irq
);

    logic pend_q;
    logic raise;

    always_comb begin
        int c, n, l;
        c = int'(count);
        n = c + int'(wr_ok) - int'(pop);
        l = fifo_en ? trig_level(trig_sel) : 1;
        raise = pop && (((c >= l) && (n < l)) || (n == 0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (raise)            pend_q <= 1'b1;
        else if (isr_rd || wr_ok)  pend_q <= 1'b0;
    end

    assign irq = pend_q && irq_en;

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int OVS   = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          irq_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          isr_rd,
    output logic          tx_out,
    output logic          thr_empty,
    output logic          tx_empty,
    output logic          tx_irq
);

    logic [DW-1:0] hold_data;
    logic [CW-1:0] hold_cnt;
    logic          hold_avail;
    logic          hold_wr_ok;
    logic          sh_load;
    logic          sh_busy;

    uart_tx_hold #(.DEPTH(DEPTH), .DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (sh_load),
        .rd_data (hold_data),
        .count   (hold_cnt),
        .avail   (hold_avail),
        .wr_ok   (hold_wr_ok)
    );

    uart_tx_shift #(.DW(DW), .OVS(OVS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .avail   (hold_avail),
        .din     (hold_data),
        .par_en  (par_en),
        .par_odd (par_odd),
        .load    (sh_load),
        .busy    (sh_busy),
        .line    (tx_out)
    );

    uart_tx_irq #(.CW(CW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .count    (hold_cnt),
        .pop      (sh_load),
        .wr_ok    (hold_wr_ok),
        .isr_rd   (isr_rd),
        .irq_en   (irq_en),
        .irq      (tx_irq)
    );

    assign thr_empty = (hold_cnt == '0);
    assign tx_empty  = thr_empty && !sh_busy;

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          baud_tick,
    input logic          irq_en,
    input logic          isr_rd,
    input logic          tx_out,
    input logic          thr_empty,
    input logic          tx_empty,
    input logic          tx_irq,
    input logic [CW-1:0] hold_cnt
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hold_cnt) <= DEPTH);

    p_line_rises_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_out) |-> $past(baud_tick));

    p_empty_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_out);

    p_empty_needs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !tx_irq);

    p_status_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && thr_empty) |=> !tx_irq);

endmodule

bind uart_tx_path uart_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .irq_en    (irq_en),
    .isr_rd    (isr_rd),
    .tx_out    (tx_out),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty),
    .tx_irq    (tx_irq),
    .hold_cnt  (hold_cnt)
);

// File: tb/uart_tx_path_tb_top.sv
module uart_tx_path_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       isr_rd = 1'b0;
    logic       tx_out, thr_empty, tx_empty, tx_irq;

    int checks = 0;
    int errors = 0;
    int tick_prob = 100;
    int rx_cnt = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    uart_tx_path #(.DEPTH(16), .DW(8), .OVS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_en(fifo_en),
        .trig_sel(trig_sel), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .isr_rd(isr_rd),
        .tx_out(tx_out), .thr_empty(thr_empty), .tx_empty(tx_empty), .tx_irq(tx_irq)
    );

    function automatic int lvl(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic exp_par(input logic [7:0] b, input logic odd);
        return (^b) ^ odd;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // tick generator, driven away from the active edge
    initial forever begin
        @(negedge clk);
        if (tick_prob >= 100)   baud_tick = 1'b1;
        else if (tick_prob <= 0) baud_tick = 1'b0;
        else baud_tick = (($urandom % 100) < tick_prob);
    end

    // line monitor: one sample per tick, 16 per bit
    logic [10:0] fbits;
    bit mon_act = 0;
    int mon_pos = 0;
    int glitches = 0;
    always @(negedge clk) begin
        if (rst_n && baud_tick) begin
            if (!mon_act) begin
                if (tx_out === 1'b0) begin
                    mon_act = 1; mon_pos = 1; fbits = '0; glitches = 0;
                end
            end else begin
                int bi, flen;
                logic [7:0] d, e;
                bi = mon_pos / 16;
                if (mon_pos % 16 == 0) fbits[bi] = tx_out;
                else if (tx_out !== fbits[bi]) glitches++;
                mon_pos++;
                flen = par_en ? 11 : 10;
                if (mon_pos == 16 * flen) begin
                    mon_act = 0;
                    rx_cnt++;
                    d = fbits[8:1];
                    chk("R2", "bit held 16 ticks", glitches, 0);
                    chk("R2", "stop bit", int'(fbits[flen-1]), 1);
                    if (par_en) chk("R2", "parity bit", int'(fbits[9]), int'(exp_par(d, par_odd)));
                    if (exp_q.size() == 0) chk("R3", "unexpected frame", int'(d), -1);
                    else begin
                        e = exp_q.pop_front();
                        chk("R2", "data byte", int'(d), int'(e));
                    end
                end
            end
        end
    end

    task automatic put(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        isr_rd = 1'b1;
        @(negedge clk);
        isr_rd = 1'b0;
    endtask

    task automatic drain();
        tick_prob = 100;
        @(negedge clk);
        while (!(tx_empty && !mon_act)) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tx_out", int'(tx_out), 1);
        chk("R1", "thr_empty", int'(thr_empty), 1);
        chk("R1", "tx_empty", int'(tx_empty), 1);
        chk("R1", "tx_irq", int'(tx_irq), 0);

        // R4, R8 single holding register
        fifo_en = 1'b0; irq_en = 1'b1; tick_prob = 100;
        repeat (2) @(negedge clk);
        put(8'hA5);
        chk("R4", "held byte not empty", int'(thr_empty), 0);
        @(negedge clk);
        chk("R4", "empty after move", int'(thr_empty), 1);
        chk("R5", "busy not empty", int'(tx_empty), 0);
        chk("R8", "irq on move", int'(tx_irq), 1);
        exp_q.push_back(8'hA5);
        put(8'h3C);
        exp_q.push_back(8'h3C);
        chk("R10", "write clears irq", int'(tx_irq), 0);
        chk("R4", "second held", int'(thr_empty), 0);
        put(8'hFF);  // dropped: register occupied
        chk("R4", "still held", int'(thr_empty), 0);
        drain();
        chk("R4", "only two frames", exp_q.size(), 0);
        chk("R4", "frame count", rx_cnt, 2);
        ack();

        // R3, R6 queue overrun with ticks stalled
        fifo_en = 1'b1; tick_prob = 0; irq_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            put(8'(8'h10 + i));
            if (i < 17) exp_q.push_back(8'(8'h10 + i));
        end
        chk("R6", "full queue not empty", int'(thr_empty), 0);
        chk("R9", "irq masked", int'(tx_irq), 0);
        rx_cnt = 0;
        drain();
        chk("R3", "17 frames accepted", rx_cnt, 17);
        chk("R3", "drops left none", exp_q.size(), 0);
        chk("R6", "empty after drain", int'(thr_empty), 1);
        chk("R9", "masked after empty event", int'(tx_irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9", "pending shows when enabled", int'(tx_irq), 1);
        ack();
        chk("R10", "read clears", int'(tx_irq), 0);

        // R7 every trigger level
        for (int s = 0; s < 4; s++) begin
            int base, l;
            l = lvl(s);
            trig_sel = 2'(s); tick_prob = 0;
            @(negedge clk);
            for (int i = 0; i < 15; i++) begin
                put(8'(8'h40 + 16 * s + i));
                exp_q.push_back(8'(8'h40 + 16 * s + i));
            end
            ack();
            chk("R10", "cleared before run", int'(tx_irq), 0);
            base = rx_cnt;
            tick_prob = 100;
            while (!tx_irq) @(negedge clk);
            chk("R7", $sformatf("frames at trigger %0d", l), rx_cnt - base, 15 - l);
            drain();
            chk("R8", "irq on drain", int'(tx_irq), 1);
            ack();
        end

        // R11 mode change discards queued bytes
        fifo_en = 1'b1; tick_prob = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) put(8'(8'hC0 + i));
        exp_q.push_back(8'hC0);
        @(negedge clk);
        fifo_en = 1'b0;
        @(negedge clk);
        chk("R11", "flushed", int'(thr_empty), 1);
        rx_cnt = 0;
        drain();
        chk("R11", "only byte in shifter sent", rx_cnt, 1);
        ack();

        // random frames in both modes
        fifo_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            int n;
            par_en = 1'($urandom % 2); par_odd = 1'($urandom % 2);
            n = 1 + int'($urandom % 16);
            tick_prob = 30 + int'($urandom % 71);
            for (int i = 0; i < n; i++) begin
                logic [7:0] v;
                v = 8'($urandom);
                exp_q.push_back(v);
                put(v);
            end
            drain();
            chk("R5", "idle after batch", int'(tx_empty), 1);
        end
        fifo_en = 1'b0; par_en = 1'b1; par_odd = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v;
            tick_prob = 50;
            while (!thr_empty) @(negedge clk);
            v = 8'($urandom);
            exp_q.push_back(v);
            put(v);
        end
        drain();
        chk("R2", "all random frames seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule